// File: doc/BRIEF.md
# Masked Interrupt and DMA Request Logic

This block sits beside the transfer engine of a serial bus controller and turns transfer events into service requests. It keeps a 16-bit event status register, an interrupt-enable mask and a DMA-enable register. From these it drives one level interrupt line and two DMA request lines, one for receive and one for transmit. The transfer logic reports events as one-cycle set pulses, one pulse bit per status bit.

Software reaches the block through a small register port. It can clear events by writing ones to the status register. It can also read a vector register, which names the lowest pending enabled event and acknowledges it in the same access. Turning on a DMA channel takes the matching ready event away from the interrupt mask, so one ready condition is never served both by the CPU and by DMA. A test write can force the six low events all at once, so the request paths can be exercised without bus traffic.

Top module: `irq_dma_ctrl`

## Requirements
- R1: `irq` is high exactly when some status bit and the mask bit in the same position are both set. It is registered, so it changes one clock after the status or mask register changes.
- R2: `dma_rx_req` equals status bit 3 ANDed with DMA-enable bit 15. `dma_tx_req` equals status bit 4 ANDed with DMA-enable bit 7. Both are registered with one clock of latency.
- R3: A write to the DMA-enable register (address 3) stores only bits 15 and 7. If bit 15 is written as 1, mask bit 3 is cleared; if bit 7 is written as 1, mask bit 4 is cleared.
- R4: A read of the vector register (address 2) returns the index plus one of the lowest set bit in status AND mask, and clears that status bit. When no such bit is set, the read returns 0 and changes nothing.
- R5: A write to the status register (address 1) clears each status bit written as 1, but only bits 0, 1, 2 and 5. Writes to bits 3, 4 and all other bits have no effect.
- R6: The mask register (address 0) keeps bits 5:0 when `NEW_LAYOUT` is 1, and bits 4:0 when it is 0. All other mask bits read back as 0.
- R7: A read of the status register returns the stored bits, except that bit 12 is replaced by the `bus_busy` input.
- R8: A write to the test register (address 4) with bit 0 set sets status bits 0 through 5 together. Reads of address 4 return 0.
- R9: When an event set pulse and a software clear (status write or vector acknowledge) hit the same status bit in the same cycle, the bit ends up set.
- R10: Synchronous active-high reset clears the status, mask and DMA-enable registers, the read data and all three request outputs.
- R11: `reg_rdata` is registered. It holds the value selected by a read strobe from the clock edge that samples `reg_rd` until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register select (0 mask, 1 status, 2 vector, 3 DMA enable, 4 test) |
| reg_wdata | input | REG_W | Write data |
| reg_rdata | output | REG_W | Registered read data |
| evt_set | input | REG_W | One-cycle set pulses from the transfer logic, one per status bit |
| bus_busy | input | 1 | Live bus-busy level, shown in status bit 12 on reads |
| irq | output | 1 | Masked interrupt request |
| dma_rx_req | output | 1 | Receive DMA request |
| dma_tx_req | output | 1 | Transmit DMA request |

## Verification
The assertions assume one register access per cycle. `reg_rd` and `reg_wr` are never both high, and strobes are held for exactly one clock. They also assume `evt_set` carries single-cycle pulses and not levels. The bench drives every access through a task that raises a single strobe for one cycle, and it pulses events through its own task. It overlaps an event with a clear only in the scenario aimed at R9, and it keeps `bus_busy` steady across each read.

// File: rtl/irq_dma_pkg.sv
package irq_dma_pkg;
  localparam int SEL_W = 3;

  typedef enum logic [SEL_W-1:0] {
    SEL_MASK = 3'd0,
    SEL_STAT = 3'd1,
    SEL_VEC  = 3'd2,
    SEL_DMA  = 3'd3,
    SEL_TEST = 3'd4
  } reg_sel_e;

  localparam int RX_RDY_BIT = 3;
  localparam int TX_RDY_BIT = 4;
  localparam int BUSY_BIT   = 12;
  localparam int RX_DMA_BIT = 15;
  localparam int TX_DMA_BIT = 7;
  localparam int FORCE_BIT  = 0;
endpackage

// File: rtl/irq_evt_status.sv
module irq_evt_status #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] stat_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)           stat_o[i] <= 1'b0;
      else if (set_i[i]) stat_o[i] <= 1'b1;
      else if (clr_i[i]) stat_o[i] <= 1'b0;
    end

    // R9: a set pulse always leaves the bit set, whatever clear arrives with it
    assert_set_wins_R9: assert property (@(posedge clk) disable iff (rst)
      set_i[i] |=> stat_o[i]);
  end
endmodule

// File: rtl/irq_vec_find.sv
module irq_vec_find #(
  parameter int W     = 16,
  parameter int IDX_W = $clog2(W)
) (
  input  logic [W-1:0]   pend_i,
  output logic           found_o,
  output logic [IDX_W:0] code_o,
  output logic [W-1:0]   hit_o
);
  always_comb begin
    found_o = 1'b0;
    code_o  = '0;
    hit_o   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (pend_i[i]) begin
        found_o = 1'b1;
        code_o  = (IDX_W+1)'(i + 1);
        hit_o   = W'(1) << i;
      end
    end
  end
endmodule

// File: rtl/irq_req_out.sv
module irq_req_out #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] stat_i,
  input  logic [W-1:0] mask_i,
  input  logic         rx_en_i,
  input  logic         tx_en_i,
  output logic         irq_o,
  output logic         rx_req_o,
  output logic         tx_req_o
);
  import irq_dma_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o    <= 1'b0;
      rx_req_o <= 1'b0;
      tx_req_o <= 1'b0;
    end else begin
      irq_o    <= |(stat_i & mask_i);
      rx_req_o <= rx_en_i & stat_i[RX_RDY_BIT];
      tx_req_o <= tx_en_i & stat_i[TX_RDY_BIT];
    end
  end

  assert_irq_follows_R1: assert property (@(posedge clk) disable iff (rst)
    (|(stat_i & mask_i)) |=> irq_o);
  assert_rx_gated_R2: assert property (@(posedge clk) disable iff (rst)
    !rx_en_i |=> !rx_req_o);
  assert_tx_gated_R2: assert property (@(posedge clk) disable iff (rst)
    !tx_en_i |=> !tx_req_o);
endmodule

// File: rtl/irq_dma_ctrl.sv
module irq_dma_ctrl #(
  parameter int REG_W      = 16,
  parameter bit NEW_LAYOUT = 1'b1
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         reg_wr,
  input  logic                         reg_rd,
  input  logic [irq_dma_pkg::SEL_W-1:0] reg_addr,
  input  logic [REG_W-1:0]             reg_wdata,
  output logic [REG_W-1:0]             reg_rdata,
  input  logic [REG_W-1:0]             evt_set,
  input  logic                         bus_busy,
  output logic                         irq,
  output logic                         dma_rx_req,
  output logic                         dma_tx_req
);
  import irq_dma_pkg::*;

  localparam int          IDX_W     = $clog2(REG_W);
  localparam int          MASK_W    = NEW_LAYOUT ? 6 : 5;
  localparam logic [REG_W-1:0] MASK_KEEP = REG_W'((1 << MASK_W) - 1);
  localparam logic [REG_W-1:0] W1C_BITS  = REG_W'(16'h0027);
  localparam logic [REG_W-1:0] FORCE_SET = REG_W'(16'h003f);
  localparam logic [REG_W-1:0] DMA_KEEP  = REG_W'((1 << RX_DMA_BIT) | (1 << TX_DMA_BIT));

  logic [REG_W-1:0] stat_q, mask_q, dma_q;
  logic [REG_W-1:0] set_all, clr_all, hit;
  logic [IDX_W:0]   vec_code;
  logic             vec_found;
  logic             wr_mask, wr_stat, wr_dma, wr_test, rd_vec;

  assign wr_mask = reg_wr && reg_addr == SEL_MASK;
  assign wr_stat = reg_wr && reg_addr == SEL_STAT;
  assign wr_dma  = reg_wr && reg_addr == SEL_DMA;
  assign wr_test = reg_wr && reg_addr == SEL_TEST;
  assign rd_vec  = reg_rd && reg_addr == SEL_VEC;

  irq_vec_find #(.W(REG_W), .IDX_W(IDX_W)) u_find (
    .pend_i (stat_q & mask_q),
    .found_o(vec_found),
    .code_o (vec_code),
    .hit_o  (hit)
  );

  assign set_all = evt_set | ((wr_test && reg_wdata[FORCE_BIT]) ? FORCE_SET : '0);
  assign clr_all = (wr_stat ? (reg_wdata & W1C_BITS) : '0) | (rd_vec ? hit : '0);

  irq_evt_status #(.W(REG_W)) u_stat (
    .clk   (clk),
    .rst   (rst),
    .set_i (set_all),
    .clr_i (clr_all),
    .stat_o(stat_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      dma_q  <= '0;
    end else if (wr_mask) begin
      mask_q <= reg_wdata & MASK_KEEP;
    end else if (wr_dma) begin
      dma_q <= reg_wdata & DMA_KEEP;
      if (reg_wdata[RX_DMA_BIT]) mask_q[RX_RDY_BIT] <= 1'b0;
      if (reg_wdata[TX_DMA_BIT]) mask_q[TX_RDY_BIT] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      unique case (reg_addr)
        SEL_MASK: reg_rdata <= mask_q;
        SEL_STAT: begin
          reg_rdata           <= stat_q;
          reg_rdata[BUSY_BIT] <= bus_busy;
        end
        SEL_VEC:  reg_rdata <= vec_found ? REG_W'(vec_code) : '0;
        SEL_DMA:  reg_rdata <= dma_q;
        default:  reg_rdata <= '0;
      endcase
    end
  end

  irq_req_out #(.W(REG_W)) u_out (
    .clk     (clk),
    .rst     (rst),
    .stat_i  (stat_q),
    .mask_i  (mask_q),
    .rx_en_i (dma_q[RX_DMA_BIT]),
    .tx_en_i (dma_q[TX_DMA_BIT]),
    .irq_o   (irq),
    .rx_req_o(dma_rx_req),
    .tx_req_o(dma_tx_req)
  );

  assert_dma_steals_rx_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_dma && reg_wdata[RX_DMA_BIT]) |=> !mask_q[RX_RDY_BIT]);
  assert_dma_steals_tx_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_dma && reg_wdata[TX_DMA_BIT]) |=> !mask_q[TX_RDY_BIT]);
  assert_vec_ack_R4: assert property (@(posedge clk) disable iff (rst)
    (rd_vec && vec_found && !(|(evt_set & hit))) |=> !(|(stat_q & $past(hit))));
  assert_ready_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_stat && !reg_rd) |=> (stat_q[RX_RDY_BIT] == $past(stat_q[RX_RDY_BIT]) || $past(evt_set[RX_RDY_BIT])));
  assert_mask_width_R6: assert property (@(posedge clk) disable iff (rst)
    (mask_q & ~MASK_KEEP) == '0);
  assert_force_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_test && reg_wdata[FORCE_BIT]) |=> ((stat_q & FORCE_SET) == FORCE_SET));
endmodule

// File: tb/irq_dma_ctrl_bench.sv
module irq_dma_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0, bus_busy = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0, evt_set = '0;
  logic [15:0] reg_rdata;
  logic        irq, dma_rx_req, dma_tx_req;
  int          total = 0, bad = 0;
  logic [15:0] rv;

  always #10 clk = ~clk;

  irq_dma_ctrl u_irq_dma_ctrl (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_set(evt_set),
    .bus_busy(bus_busy), .irq(irq), .dma_rx_req(dma_rx_req), .dma_tx_req(dma_tx_req)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  task automatic settle(); @(negedge clk); endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic pulse(input logic [15:0] e);
    @(negedge clk); evt_set = e;
    @(negedge clk); evt_set = '0;
  endtask

  task automatic t_reset();
    do_reset();
    rd(0, rv); chk("R10 mask", rv, 16'h0);
    rd(1, rv); chk("R10 status", rv, 16'h0);
    rd(3, rv); chk("R10 dma", rv, 16'h0);
    chk("R10 outputs", {13'd0, irq, dma_rx_req, dma_tx_req}, 16'h0);
  endtask

  task automatic t_irq();
    do_reset();
    pulse(16'h0004); settle();
    chk("R1 unmasked irq low", {15'd0, irq}, 16'h0);
    rd(1, rv); chk("R11 status read", rv, 16'h0004);
    wr(0, 16'h0004);
    chk("R1 latency one cycle", {15'd0, irq}, 16'h0);
    settle(); chk("R1 irq high", {15'd0, irq}, 16'h1);
    rd(2, rv); chk("R4 vector bit2", rv, 16'd3);
    settle(); chk("R1 irq low after ack", {15'd0, irq}, 16'h0);
  endtask

  task automatic t_vec();
    do_reset();
    wr(0, 16'h003f);
    pulse(16'h0122);
    rd(2, rv); chk("R4 vector lowest", rv, 16'd2);
    rd(2, rv); chk("R4 vector next", rv, 16'd6);
    rd(2, rv); chk("R4 vector none", rv, 16'd0);
    rd(1, rv); chk("R4 unmasked kept", rv, 16'h0100);
  endtask

  task automatic t_w1c();
    do_reset();
    wr(4, 16'h0001);
    rd(1, rv); chk("R8 force", rv, 16'h003f);
    rd(4, rv); chk("R8 test reads zero", rv, 16'h0);
    wr(1, 16'hffff);
    rd(1, rv); chk("R5 ready bits kept", rv, 16'h0018);
  endtask

  task automatic t_dma();
    do_reset();
    wr(0, 16'hffff);
    rd(0, rv); chk("R6 mask width", rv, 16'h003f);
    wr(4, 16'h0001);
    settle(); settle();
    chk("R2 no dma when disabled", {14'd0, dma_rx_req, dma_tx_req}, 16'h0);
    wr(3, 16'hffff);
    rd(3, rv); chk("R3 dma keep", rv, 16'h8080);
    rd(0, rv); chk("R3 mask stolen", rv, 16'h0027);
    chk("R2 both req", {14'd0, dma_rx_req, dma_tx_req}, 16'h3);
    wr(3, 16'h0080);
    settle();
    chk("R2 tx only", {14'd0, dma_rx_req, dma_tx_req}, 16'h1);
    t_reset();
  endtask

  task automatic t_busy();
    do_reset();
    pulse(16'h1000);
    bus_busy = 1'b0;
    rd(1, rv); chk("R7 busy low hides bit", rv, 16'h0000);
    bus_busy = 1'b1;
    rd(1, rv); chk("R7 busy high", rv, 16'h1000);
    bus_busy = 1'b0;
  endtask

  task automatic t_prio();
    do_reset();
    @(negedge clk); reg_wr = 1'b1; reg_addr = 3'd1; reg_wdata = 16'h0001; evt_set = 16'h0001;
    @(negedge clk); reg_wr = 1'b0; evt_set = '0;
    rd(1, rv); chk("R9 set beats clear", rv, 16'h0001);
    wr(1, 16'h0001);
    rd(1, rv); chk("R5 clear alone", rv, 16'h0000);
  endtask

  initial begin
    t_reset();
    t_irq();
    t_vec();
    t_w1c();
    t_dma();
    t_busy();
    t_prio();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule